// File: doc/BRIEF.md
# Dual-Factor Power-Mode Clock Divider

This block derives the general system clock rate from a fast input clock that comes from the VCO. It runs in the input clock domain and produces a clock-enable pulse, one input cycle wide, once per divided period. Downstream logic either gates on this pulse or feeds it to a clock-gating cell. A status port reports the power-of-two exponent of the ratio currently applied.

Two 3-bit factor codes are loaded through a single-cycle write port. One code is for normal operation and one is for low-power operation, and each code has its own power-of-two table. The low table is picked when the written source-select bit is set or when the low-power mode input is high. Otherwise the normal table is picked.

A new ratio never cuts a divided period short. The ratio in force finishes its current period, and the new ratio starts at the period boundary. The upstream PLL is never disturbed, because all ratio changes happen inside this counter.

Top module: `pm_clk_divider`

## Requirements
- R1: After reset both codes and the source bit are 0. `applied_shift` reads 0, `clk_en` is high in every cycle, and `bad_code` is 0.
- R2: For the normal-mode code, values 0 to 6 select a divide by 2^code. `applied_shift` equals the code, and `clk_en` pulses once every 2^code cycles.
- R3: A normal-mode code of 7 is reserved. It divides by 64 (`applied_shift` = 6) and sets `bad_code`.
- R4: For the low-power code, values 0 to 5 select a divide by 2^(code+1), which is 2 to 64.
- R5: A low-power code of 6 is reserved. It divides by 64 and sets `bad_code`. A low-power code of 7 divides by 256 (`applied_shift` = 8).
- R6: The low-power code is used when the written source bit is 1 or `lp_mode` is 1. The normal code is used only when both are 0.
- R7: A change of the selected ratio is applied only at a period boundary. `applied_shift` holds its old value until the `clk_en` pulse that ends the current period, then takes the new value in the next cycle.
- R8: Once set, `bad_code` stays set through later legal writes until reset.
- R9: When the ratio is 2 or more, `clk_en` is high for exactly one cycle per period and low in the cycle after each pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock derived from the VCO |
| rst_n | input | 1 | Active-low power-on/hard reset |
| wr_en | input | 1 | Write strobe for the code fields |
| wr_lo_code | input | 3 | Low-power factor code |
| wr_hi_code | input | 3 | Normal-mode factor code |
| wr_lo_sel | input | 1 | Clock-source bit, 1 forces the low-power factor |
| lp_mode | input | 1 | Low-power mode indication |
| clk_en | output | 1 | Divided-clock enable pulse |
| applied_shift | output | 4 | log2 of the ratio in force |
| bad_code | output | 1 | Sticky flag for a reserved code written |

## Verification
A write lands at the first edge after the strobe. `bad_code` is visible one cycle later. The ratio itself waits for the current period to end, so `applied_shift` changes in the cycle after the next `clk_en` pulse. The first full period at the new ratio follows that. The bench therefore lets two pulses pass after every change before it measures a pulse-to-pulse gap, and it samples every output on the falling edge. In the boundary test it checks `applied_shift` on each cycle until the pulse arrives, and then on the cycle right after the pulse.

// File: rtl/pm_clk_divider.sv
module pm_clk_divider #(
  parameter int CW = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [2:0]                 wr_lo_code,
  input  logic [2:0]                 wr_hi_code,
  input  logic                       wr_lo_sel,
  input  logic                       lp_mode,
  output logic                       clk_en,
  output logic [$clog2(CW+1)-1:0]    applied_shift,
  output logic                       bad_code
);
  localparam int SW = $clog2(CW+1);

  logic [2:0]    lo_code, hi_code;
  logic          lo_sel;
  logic [CW-1:0] cnt, mask;
  logic [CW:0]   full;
  logic [SW-1:0] lo_shift, hi_shift, tgt_shift;

  always_comb begin
    case (lo_code)
      3'd6:    lo_shift = SW'(6);
      3'd7:    lo_shift = SW'(8);
      default: lo_shift = SW'(lo_code) + SW'(1);
    endcase
    hi_shift = (hi_code == 3'd7) ? SW'(6) : SW'(hi_code);
  end

  assign tgt_shift = (lo_sel || lp_mode) ? lo_shift : hi_shift;
  assign full      = (CW+1)'(1) << applied_shift;
  assign mask      = CW'(full - (CW+1)'(1));
  assign clk_en    = (cnt == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_code  <= '0;
      hi_code  <= '0;
      lo_sel   <= 1'b0;
      bad_code <= 1'b0;
    end else if (wr_en) begin
      lo_code <= wr_lo_code;
      hi_code <= wr_hi_code;
      lo_sel  <= wr_lo_sel;
      if (wr_lo_code == 3'd6 || wr_hi_code == 3'd7) bad_code <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt           <= '0;
      applied_shift <= '0;
    end else if (clk_en) begin
      cnt           <= '0;
      applied_shift <= tgt_shift;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

module pm_clk_divider_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clk_en,
  input logic [3:0] applied_shift,
  input logic       bad_code
);
  assert_div1_always_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (applied_shift == 4'd0) |-> clk_en);
  assert_switch_at_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(applied_shift) |-> $past(clk_en));
  assert_sticky_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bad_code |=> bad_code);
  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |=> (applied_shift == 4'd0 || !clk_en));
  always @(negedge clk)
    if (rst_n) assert_legal_shift_R5: assert (applied_shift <= 4'd8 && applied_shift != 4'd7);
endmodule

bind pm_clk_divider pm_clk_divider_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
  .applied_shift(applied_shift), .bad_code(bad_code));

// File: tb/pm_clk_divider_test.sv
module pm_clk_divider_test;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, wr_lo_sel = 1'b0, lp_mode = 1'b0;
  logic [2:0] wr_lo_code = '0, wr_hi_code = '0;
  logic clk_en, bad_code;
  logic [3:0] applied_shift;
  int n_chk = 0, n_bad = 0, cycles = 0;

  pm_clk_divider uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_lo_code(wr_lo_code),
    .wr_hi_code(wr_hi_code), .wr_lo_sel(wr_lo_sel), .lp_mode(lp_mode),
    .clk_en(clk_en), .applied_shift(applied_shift), .bad_code(bad_code));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      chk(0, "watchdog", cycles, 190000);
      finish_run();
    end
  end

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; wr_en = 1'b0; lp_mode = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic write(input logic [2:0] lo, input logic [2:0] hi, input logic sel);
    @(negedge clk);
    wr_en = 1'b1; wr_lo_code = lo; wr_hi_code = hi; wr_lo_sel = sel;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_pulse();
    int n = 0;
    do begin @(negedge clk); n++; end while (!clk_en && n < 1000);
  endtask

  task automatic gap(output int g);
    g = 0;
    do begin @(negedge clk); g++; end while (!clk_en && g < 1000);
  endtask

  task automatic check_ratio(input int exp_shift, input string req);
    int g;
    wait_pulse(); wait_pulse(); wait_pulse();
    gap(g);
    chk(g == (1 << exp_shift), req, g, 1 << exp_shift);
    chk(applied_shift == exp_shift, req, applied_shift, exp_shift);
    if (exp_shift > 0) begin
      @(negedge clk);
      chk(clk_en == 1'b0, "R9", clk_en, 0);
    end
  endtask

  task automatic t_reset();
    chk(applied_shift == 0, "R1", applied_shift, 0);
    chk(clk_en == 1'b1, "R1", clk_en, 1);
    chk(bad_code == 1'b0, "R1", bad_code, 0);
    check_ratio(0, "R1");
  endtask

  task automatic t_hi_table();
    for (int c = 0; c < 7; c++) begin
      write(3'd0, 3'(c), 1'b0);
      check_ratio(c, "R2");
    end
    chk(bad_code == 1'b0, "R2", bad_code, 0);
  endtask

  task automatic t_hi_reserved();
    write(3'd0, 3'd7, 1'b0);
    check_ratio(6, "R3");
    chk(bad_code == 1'b1, "R3", bad_code, 1);
    write(3'd0, 3'd2, 1'b0);
    check_ratio(2, "R8");
    chk(bad_code == 1'b1, "R8", bad_code, 1);
    do_reset();
    chk(bad_code == 1'b0, "R1", bad_code, 0);
  endtask

  task automatic t_lo_table();
    for (int c = 0; c < 6; c++) begin
      write(3'(c), 3'd0, 1'b1);
      check_ratio(c + 1, "R4");
    end
    chk(bad_code == 1'b0, "R4", bad_code, 0);
  endtask

  task automatic t_lo_reserved();
    write(3'd7, 3'd0, 1'b1);
    check_ratio(8, "R5");
    chk(bad_code == 1'b0, "R5", bad_code, 0);
    write(3'd6, 3'd0, 1'b1);
    check_ratio(6, "R5");
    chk(bad_code == 1'b1, "R5", bad_code, 1);
    do_reset();
  endtask

  task automatic t_select();
    write(3'd2, 3'd1, 1'b0);
    check_ratio(1, "R6");
    write(3'd2, 3'd1, 1'b1);
    check_ratio(3, "R6");
    write(3'd2, 3'd1, 1'b0);
    lp_mode = 1'b1;
    check_ratio(3, "R6");
    lp_mode = 1'b0;
    check_ratio(1, "R6");
  endtask

  task automatic t_boundary();
    int n = 0;
    bit held = 1'b1;
    write(3'd0, 3'd4, 1'b0);
    check_ratio(4, "R7");
    wait_pulse();
    @(negedge clk); @(negedge clk);
    wr_en = 1'b1; wr_hi_code = 3'd0;
    @(negedge clk);
    wr_en = 1'b0;
    while (!clk_en && n < 40) begin
      if (applied_shift != 4) held = 1'b0;
      @(negedge clk); n++;
    end
    chk(held, "R7", held, 1);
    chk(applied_shift == 4, "R7", applied_shift, 4);
    chk(n == 13, "R7", n, 13);
    @(negedge clk);
    chk(applied_shift == 0, "R7", applied_shift, 0);
    chk(clk_en == 1'b1, "R7", clk_en, 1);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_hi_table();
    t_hi_reserved();
    t_lo_table();
    t_lo_reserved();
    t_select();
    t_boundary();
    finish_run();
  end
endmodule